// File: doc/BRIEF.md
# Wakeup Event Detector

This block watches a single asynchronous wakeup pin and produces a wake request that can bring the system out of a low-power state. Software chooses the kind of event that counts as a wakeup: a low level, a high level, a falling edge, a rising edge, or either edge. A separate enable bit gates the request. The input is synchronized into the clock domain before any level or edge test is made.

When the either-edge mode is selected, the block also keeps a sticky two-bit record of which edge polarities it has seen since the record was last cleared. Software reads this record, and clears it with a dedicated strobe or as a side effect of any write to the control register. Mode codes outside the five defined ones are accepted into the register but never produce a wake request.

All control and status live in one 8-bit register at a parameterized address. In level modes the request follows the synchronized pin for as long as it is enabled. In edge modes the request is a single-cycle pulse.

Top module: `wkp_event_detector`

## Requirements
- R1: After reset the register reads 0x00 (mode 000, disabled, status 00) and wake_req is 0.
- R2: The mode field (bits [2:0]) and the enable bit (bit 7) are written by a register write to REG_ADDR and read back unchanged. Bits 6 and 3 read as 0. A write to any other address changes nothing, and reading any other address returns 0.
- R3: The wakeup pin passes through a two-stage synchronizer. A change driven on the pin is first seen by the detection logic in the clock cycle that follows the second rising clock edge after the change.
- R4: Mode 000 (low) and mode 001 (high) make wake_req follow the synchronized pin while the enable bit is 1. It is 1 while the pin is at the selected level and 0 otherwise.
- R5: Mode 011 (rising) and mode 010 (falling) give a one-cycle wake_req pulse for each edge of the selected polarity and nothing for the other polarity.
- R6: Mode 100 (either edge) gives a one-cycle wake_req pulse for every rising and every falling edge.
- R7: In mode 100, status bit 4 becomes 1 after a rising edge and status bit 5 becomes 1 after a falling edge, so the status reads 01, 10 or 11. These bits stay set until cleared, and they update one cycle after the edge is seen.
- R8: The status field is read-only, and a write to bits [5:4] has no effect. Pulsing status_clr or writing the register resets it to 00. A clear takes priority over an edge seen in the same cycle.
- R9: In any mode other than 100, the status field reads 00.
- R10: Mode codes 101, 110 and 111 read back as written but never cause wake_req, whatever the pin does.
- R11: With the enable bit at 0, wake_req stays 0 in every mode.
- R12: An edge that reaches the detection logic in the first cycle after a write that changes the mode field is not reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| wake_in | input | 1 | Asynchronous wakeup pin |
| status_clr | input | 1 | Strobe that clears the edge status record |
| wake_req | output | 1 | Wake request: a level in level modes, a pulse in edge modes |

## Verification
The embedded assertions check the following on every cycle:
- wake_req stays 0 under a reserved mode code or a cleared enable.
- An edge-mode pulse never lasts longer than one cycle.
- The status bits only accumulate between clears.
- No edge request appears in the cycle after a mode change.
- A register write lands in the mode field.
- The status field reads zero outside the either-edge mode.

Only the directed scenarios can show the following:
- The exact two-cycle synchronizer latency.
- Which edge polarities qualify in each mode.
- The status codes produced by particular edge sequences.
- That a write to the status bits or to another address is ignored.
- That a mode change suppresses an edge which is actually in flight.

// File: rtl/wkp_pkg.sv
// Package wkp_pkg
// Shared constants for the wakeup event detector: the mode codes and the
// bit positions of the control register fields.
package wkp_pkg;

    localparam logic [2:0] MODE_LOW  = 3'b000;
    localparam logic [2:0] MODE_HIGH = 3'b001;
    localparam logic [2:0] MODE_FALL = 3'b010;
    localparam logic [2:0] MODE_RISE = 3'b011;
    localparam logic [2:0] MODE_ANY  = 3'b100;

    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 3;
    localparam int STAT_LSB = 4;
    localparam int STAT_W   = 2;
    localparam int EN_BIT   = 7;
    localparam int REG_MIN_W = 8;

    // True for the three codes above MODE_ANY, which detect nothing.
    function automatic logic mode_reserved(input logic [2:0] m);
        return m > MODE_ANY;
    endfunction

endpackage

// File: rtl/wkp_sync.sv
// Module wkp_sync
// Multi-stage synchronizer for one asynchronous bit.
// Assumes STAGES >= 2. The output lags the input by STAGES clock edges.
module wkp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wkp_regs.sv
// Module wkp_regs
// Holds the control register: the mode field and the enable bit are written
// by software. The read path merges in the status supplied by the detector.
// It also flags a write hit and a write that changes the mode.
// Assumes DATA_W >= 8 and single-cycle write strobes.
module wkp_regs
    import wkp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              en_o,
    output logic              wr_hit_o,
    output logic              mode_chg_o
);
    logic [MODE_W-1:0] mode_q;
    logic              en_q;
    logic              sel;
    logic              unused_wbits;

    assign sel          = (addr_i == REG_ADDR);
    assign wr_hit_o     = wr_en_i && sel;
    assign mode_chg_o   = wr_hit_o && (wdata_i[MODE_LSB +: MODE_W] != mode_q);
    assign unused_wbits = ^wdata_i;

    // Capture the writable fields on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LOW;
            en_q   <= 1'b0;
        end else if (wr_hit_o) begin
            mode_q <= wdata_i[MODE_LSB +: MODE_W];
            en_q   <= wdata_i[EN_BIT];
        end
    end

    // Assemble read data; unused bits and other addresses read zero.
    always_comb begin
        rdata_o = '0;
        if (sel) begin
            rdata_o[MODE_LSB +: MODE_W] = mode_q;
            rdata_o[STAT_LSB +: STAT_W] = status_i;
            rdata_o[EN_BIT]             = en_q;
        end
    end

    assign mode_o = mode_q;
    assign en_o   = en_q;

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit_o |=> (mode_o == $past(wdata_i[MODE_LSB +: MODE_W])) && (en_o == $past(wdata_i[EN_BIT])));

    assert_status_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mode_q != MODE_ANY) |-> (rdata_o[STAT_LSB +: STAT_W] == '0));
endmodule

// File: rtl/wkp_detect.sv
// Module wkp_detect
// Level and edge detection on the synchronized pin, plus the sticky edge
// status record for the either-edge mode.
// Assumes lvl_i is already synchronous. A mode change (mode_chg_i, seen in
// the cycle the write commits) disarms edge detection for one cycle.
module wkp_detect
    import wkp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              mode_chg_i,
    output logic              wake_o,
    output logic [STAT_W-1:0] status_o
);
    logic              prev_q;
    logic              arm_q;
    logic [STAT_W-1:0] stat_q;
    logic              rise;
    logic              fall;
    logic              hit;

    assign rise = arm_q &&  lvl_i && !prev_q;
    assign fall = arm_q && !lvl_i &&  prev_q;

    // Keep the previous sample, and re-arm edge detection unless the mode is changing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            arm_q  <= !mode_chg_i;
        end
    end

    // Select the qualifying condition for the current mode.
    always_comb begin
        case (mode_i)
            MODE_LOW:  hit = !lvl_i;
            MODE_HIGH: hit =  lvl_i;
            MODE_FALL: hit = fall;
            MODE_RISE: hit = rise;
            MODE_ANY:  hit = rise || fall;
            default:   hit = 1'b0;
        endcase
    end

    assign wake_o = en_i && hit;

    // Accumulate the edge record in either-edge mode; a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= '0;
        else if (clr_i)             stat_q <= '0;
        else if (mode_i == MODE_ANY) stat_q <= stat_q | {fall, rise};
    end

    assign status_o = (mode_i == MODE_ANY) ? stat_q : '0;

    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reserved(mode_i) |-> !wake_o);

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !wake_o);

    assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && (mode_i == MODE_RISE || mode_i == MODE_FALL) && !mode_chg_i) |=> !wake_o);

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ANY && !clr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_change_mutes_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_i |=> !(wake_o && (mode_i == MODE_RISE || mode_i == MODE_FALL || mode_i == MODE_ANY)));
endmodule

// File: rtl/wkp_event_detector.sv
// Module wkp_event_detector
// Top level: synchronizes the wakeup pin and hands the result to the detector.
// The detector's status and the register block's fields are cross-connected.
// Assumes one clock domain and a synchronous active-low reset.
module wkp_event_detector
    import wkp_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wake_in,
    input  logic              status_clr,
    output logic              wake_req
);
    logic              lvl_sync;
    logic [MODE_W-1:0] mode;
    logic              en;
    logic              wr_hit;
    logic              mode_chg;
    logic [STAT_W-1:0] status;

    initial begin
        assert (DATA_W >= REG_MIN_W) else $error("DATA_W too small");
        assert (SYNC_STAGES >= 2)    else $error("SYNC_STAGES too small");
    end

    wkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(wake_in),
        .sync_o (lvl_sync)
    );

    wkp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .wr_en_i   (reg_wr_en),
        .wdata_i   (reg_wdata),
        .status_i  (status),
        .rdata_o   (reg_rdata),
        .mode_o    (mode),
        .en_o      (en),
        .wr_hit_o  (wr_hit),
        .mode_chg_o(mode_chg)
    );

    wkp_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_sync),
        .mode_i    (mode),
        .en_i      (en),
        .clr_i     (status_clr || wr_hit),
        .mode_chg_i(mode_chg),
        .wake_o    (wake_req),
        .status_o  (status)
    );
endmodule

// File: tb/tb_wkp_event_detector.sv
`timescale 1ns/1ps
module tb_wkp_event_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wake_in = 1'b0;
    logic       status_clr = 1'b0;
    logic       wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wkp_event_detector dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_in(wake_in),
        .status_clr(status_clr), .wake_req(wake_req)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = '0;
    endtask

    task automatic reg_rd(logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = '0;
    endtask

    // Drive the pin at a negedge, then step two negedges: the detector sees it now.
    task automatic pin_to(logic v);
        @(negedge clk); wake_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_rd(4'd0, d);
        check("R1", "reg after reset", d, 8'h00);
        check("R1", "wake after reset", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        reg_wr(4'd0, 8'hFC);
        reg_rd(4'd0, d);
        check("R8", "status bits not writable", d, 8'h84);
        reg_wr(4'd1, 8'h03);
        reg_rd(4'd0, d);
        check("R2", "other address write ignored", d, 8'h84);
        reg_rd(4'd1, d);
        check("R2", "other address reads zero", d, 8'h00);
        reg_wr(4'd0, 8'h00);
    endtask

    task automatic t_level();
        reg_wr(4'd0, 8'h80);
        check("R4", "low mode, pin low", {7'd0, wake_req}, 8'h01);
        @(negedge clk); wake_in = 1'b1;
        @(negedge clk);
        check("R3", "one edge after pin rise, low still seen", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R3", "two edges after pin rise", {7'd0, wake_req}, 8'h00);
        reg_wr(4'd0, 8'h81);
        check("R4", "high mode, pin high", {7'd0, wake_req}, 8'h01);
        idle(3);
        check("R4", "high mode holds level", {7'd0, wake_req}, 8'h01);
        pin_to(1'b0);
        check("R4", "high mode, pin low", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_edge();
        reg_wr(4'd0, 8'h83);
        idle(2);
        pin_to(1'b1);
        check("R5", "rising pulse", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R5", "rising pulse one cycle", {7'd0, wake_req}, 8'h00);
        pin_to(1'b0);
        check("R5", "falling ignored in rise mode", {7'd0, wake_req}, 8'h00);
        reg_wr(4'd0, 8'h82);
        idle(2);
        pin_to(1'b1);
        check("R5", "rising ignored in fall mode", {7'd0, wake_req}, 8'h00);
        pin_to(1'b0);
        check("R5", "falling pulse", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R5", "falling pulse one cycle", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d;
        reg_wr(4'd0, 8'h84);
        idle(2);
        reg_rd(4'd0, d);
        check("R7", "status starts clear", d, 8'h84);
        pin_to(1'b1);
        check("R6", "pulse on rise", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        check("R6", "pulse ends", {7'd0, wake_req}, 8'h00);
        reg_rd(4'd0, d);
        check("R7", "status rise", d, 8'h94);
        pin_to(1'b0);
        check("R6", "pulse on fall", {7'd0, wake_req}, 8'h01);
        @(negedge clk);
        reg_rd(4'd0, d);
        check("R7", "status both", d, 8'hB4);
        idle(3);
        reg_rd(4'd0, d);
        check("R7", "status sticky", d, 8'hB4);
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
        reg_rd(4'd0, d);
        check("R8", "clear strobe", d, 8'h84);
        pin_to(1'b1);
        @(negedge clk);
        reg_rd(4'd0, d);
        check("R7", "status rise again", d, 8'h94);
        reg_wr(4'd0, 8'h84);
        reg_rd(4'd0, d);
        check("R8", "write clears status", d, 8'h84);
        pin_to(1'b0);
        @(negedge clk);
        reg_rd(4'd0, d);
        check("R7", "status fall only", d, 8'hA4);
        reg_wr(4'd0, 8'h83);
        pin_to(1'b1);
        @(negedge clk);
        reg_rd(4'd0, d);
        check("R9", "status masked in rise mode", d, 8'h83);
        pin_to(1'b0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        bit seen;
        for (int c = 5; c < 8; c++) begin
            reg_wr(4'd0, 8'h80 | 8'(c));
            reg_rd(4'd0, d);
            check("R10", "reserved code reads back", d, 8'h80 | 8'(c));
            seen = 0;
            @(negedge clk); wake_in = 1'b1;
            for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= wake_req; end
            wake_in = 1'b0;
            for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= wake_req; end
            check("R10", "no wake under reserved code", {7'd0, seen}, 8'h00);
        end
    endtask

    task automatic t_disable();
        bit seen = 0;
        reg_wr(4'd0, 8'h04);
        idle(2);
        @(negedge clk); wake_in = 1'b1;
        for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= wake_req; end
        wake_in = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= wake_req; end
        check("R11", "no wake when disabled, edge mode", {7'd0, seen}, 8'h00);
        reg_wr(4'd0, 8'h00);
        idle(1);
        check("R11", "no wake when disabled, low mode", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_mode_change();
        reg_wr(4'd0, 8'h84);
        idle(3);
        @(negedge clk); wake_in = 1'b1;
        @(negedge clk);
        reg_addr = 4'd0; reg_wdata = 8'h83; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R12", "edge muted after mode change", {7'd0, wake_req}, 8'h00);
        @(negedge clk);
        check("R12", "no late pulse", {7'd0, wake_req}, 8'h00);
        pin_to(1'b0);
        pin_to(1'b1);
        check("R12", "later rise detected", {7'd0, wake_req}, 8'h01);
        pin_to(1'b0);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_both();
        t_reserved();
        t_disable();
        t_mode_change();
        idle(2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule